// File: doc/BRIEF.md
# Dual-Tone Digital Sine Synthesizer

This block turns a 4-bit key code into two digitally synthesized sine sample streams. One stream is the row (low group) tone and the other is the column (high group) tone. The block also outputs their sum. The block steps on a clock enable that marks ticks of a 3.579545 MHz time base.

Each tone has its own segment divider. It counts enabled ticks up to a per-group count, which is chosen from the key code. Each time the divider wraps, it advances a 5-bit phase counter by one. The phase counter addresses a 32-point sine table. The output frequency is therefore the tick rate divided by 32 times the count. The row stream is scaled about 2 dB below the column stream.

A single-tone mode passes only one of the two groups. An enable input forces every output to zero and parks both phase counters at zero.

A host writes a new key code with a one-cycle strobe. Both tones restart from phase zero on that write. The samples feed a DAC outside this block.

Top module: `dual_tone_synth`

## Requirements
- R1: A write of the key code selects the row divider count from the row of the digit and the column count from its column. Row counts are 160, 146, 132, 118 and column counts are 92, 84, 76, 68. Codes 1, 2, 3 and 13 use row 0, codes 4, 5, 6 and 14 use row 1, codes 7, 8, 9 and 15 use row 2, and codes 0, 10, 11 and 12 use row 3. Codes 1, 4, 7 and 11 use column 0, codes 2, 5, 8 and 10 use column 1, codes 3, 6, 9 and 12 use column 2, and codes 0, 13, 14 and 15 use column 3. Each phase step lasts exactly count enabled ticks, so one period is 32 × count ticks.
- R2: The column sample at phase p (0 to 31) equals round(127·sin(2πp/32)), with rounding half away from zero. The sample is never −128.
- R3: The row sample at phase p has the sign of the column-table value at p. Its magnitude is floor(|column-table value| × 101 / 128).
- R4: tone_out is the 9-bit signed sum of the row_smp and col_smp outputs and never wraps.
- R5: With single_tone high, col_sel high zeroes row_smp, and col_sel low zeroes col_smp. tone_out then carries only the remaining tone.
- R6: While tx_en is low, all three outputs read zero on the following cycle and both phases are held at zero. When tx_en goes high again, the tone starts from phase 0.
- R7: A code write restarts both dividers and both phase counters at zero. The new counts apply from the next tick.
- R8: A cycle with clk_en low does not move either divider or either phase.
- R9: After reset, all outputs are zero and the selected digit is code 0 (row count 118, column count 68).
- R10: An output reflects the phase held two clock cycles earlier: one register for the table read and one for the output stage.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_en | input | 1 | Tone time-base tick (3.579545 MHz rate) |
| code_we | input | 1 | One-cycle strobe that loads a key code |
| code | input | 4 | Key code |
| tx_en | input | 1 | Output enable; low gates outputs to zero |
| single_tone | input | 1 | High selects single-tone output |
| col_sel | input | 1 | In single-tone mode: high column, low row |
| row_smp | output | 8 | Signed row tone sample |
| col_smp | output | 8 | Signed column tone sample |
| tone_out | output | 9 | Signed sum of row and column samples |

## Verification
A wrong divider count or a misdecoded key code leaves the sample sequence at the right values but changes when each value is held. This shows up within the first phase step, at most 160 ticks after a write. An error in the sine table or the amplitude scaling corrupts the sample value on the very step that addresses the faulty entry, so a full period exposes all 32 entries. A phase that fails to restart on a write or on disable shifts every later sample by a fixed offset. This is visible two cycles after the event.

// File: rtl/dtsynth_pkg.sv
package dtsynth_pkg;
  localparam int unsigned NUM_GRP = 4;
  localparam int unsigned PH_W    = 5;
  localparam int unsigned SMP_W   = 8;
  localparam int unsigned SUM_W   = SMP_W + 1;
  localparam int unsigned QTR_W   = SMP_W - 1;

  typedef logic [NUM_GRP-1:0] grp_oh_t;
  typedef logic [PH_W-1:0]    phase_t;

  // first quadrant of a 127-peak sine, 9 points (0..8 of 32)
  function automatic logic [QTR_W-1:0] quarter_sine(input logic [3:0] idx);
    logic [QTR_W-1:0] v;
    case (idx)
      4'd0:    v = 7'd0;
      4'd1:    v = 7'd25;
      4'd2:    v = 7'd49;
      4'd3:    v = 7'd71;
      4'd4:    v = 7'd90;
      4'd5:    v = 7'd106;
      4'd6:    v = 7'd117;
      4'd7:    v = 7'd125;
      default: v = 7'd127;
    endcase
    return v;
  endfunction

  // key code -> {column one-hot, row one-hot}
  function automatic logic [2*NUM_GRP-1:0] key_to_lines(input logic [3:0] key);
    logic [1:0] r;
    logic [1:0] c;
    case (key)
      4'd0:  begin r = 2'd3; c = 2'd3; end
      4'd10: begin r = 2'd3; c = 2'd1; end
      4'd11: begin r = 2'd3; c = 2'd0; end
      4'd12: begin r = 2'd3; c = 2'd2; end
      4'd13, 4'd14, 4'd15: begin r = 2'(key - 4'd13); c = 2'd3; end
      default: begin
        r = 2'((key - 4'd1) / 4'd3);
        c = 2'((key - 4'd1) % 4'd3);
      end
    endcase
    return {grp_oh_t'(1) << c, grp_oh_t'(1) << r};
  endfunction
endpackage

// File: rtl/dts_decoder.sv
module dts_decoder
  import dtsynth_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       code_we,
  input  logic [3:0] code,
  output grp_oh_t    row_oh,
  output grp_oh_t    col_oh
);
  localparam logic [2*NUM_GRP-1:0] RST_LINES = key_to_lines(4'd0);

  always_ff @(posedge clk) begin
    if (rst) begin
      {col_oh, row_oh} <= RST_LINES;
    end else if (code_we) begin
      {col_oh, row_oh} <= key_to_lines(code);
    end
  end
endmodule

// File: rtl/dts_tone_gen.sv
module dts_tone_gen
  import dtsynth_pkg::*;
#(
  parameter int unsigned DIV_W   = 8,
  parameter int unsigned GAIN    = 128,
  parameter int unsigned GAIN_SH = 7,
  parameter int unsigned DIV_CNT [NUM_GRP] = '{160, 146, 132, 118}
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clk_en,
  input  logic                    restart,
  input  grp_oh_t                 sel_oh,
  output phase_t                  phase,
  output logic signed [SMP_W-1:0] smp
);
  localparam int unsigned PROD_W = QTR_W + 9;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] div_last;

  always_comb begin
    div_last = '0;
    for (int i = 0; i < NUM_GRP; i++) begin
      if (sel_oh[i]) div_last = div_last | DIV_W'(DIV_CNT[i] - 1);
    end
  end

  // segment divider and phase counter
  always_ff @(posedge clk) begin
    if (rst || restart) begin
      div_q <= '0;
      phase <= '0;
    end else if (clk_en) begin
      if (div_q == div_last) begin
        div_q <= '0;
        phase <= phase + 1'b1;
      end else begin
        div_q <= div_q + 1'b1;
      end
    end
  end

  // table read: quadrant fold, gain, sign
  logic [3:0]        q_idx;
  logic [QTR_W-1:0]  q_mag;
  logic [PROD_W-1:0] q_prod;
  logic [QTR_W-1:0]  q_scaled;

  always_comb begin
    q_idx    = phase[3] ? (4'd8 - {1'b0, phase[2:0]}) : {1'b0, phase[2:0]};
    q_mag    = quarter_sine(q_idx);
    q_prod   = PROD_W'(q_mag) * PROD_W'(GAIN);
    q_scaled = QTR_W'(q_prod >> GAIN_SH);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      smp <= '0;
    end else if (phase[PH_W-1]) begin
      smp <= -$signed({1'b0, q_scaled});
    end else begin
      smp <= $signed({1'b0, q_scaled});
    end
  end
endmodule

// File: rtl/dts_mixer.sv
module dts_mixer
  import dtsynth_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    tx_en,
  input  logic                    single_tone,
  input  logic                    col_sel,
  input  logic signed [SMP_W-1:0] row_raw,
  input  logic signed [SMP_W-1:0] col_raw,
  output logic signed [SMP_W-1:0] row_smp,
  output logic signed [SMP_W-1:0] col_smp,
  output logic signed [SUM_W-1:0] tone_out
);
  logic                    pass_row;
  logic                    pass_col;
  logic signed [SMP_W-1:0] row_n;
  logic signed [SMP_W-1:0] col_n;

  always_comb begin
    pass_row = tx_en && (!single_tone || !col_sel);
    pass_col = tx_en && (!single_tone ||  col_sel);
    row_n    = pass_row ? row_raw : '0;
    col_n    = pass_col ? col_raw : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      row_smp  <= '0;
      col_smp  <= '0;
      tone_out <= '0;
    end else begin
      row_smp  <= row_n;
      col_smp  <= col_n;
      tone_out <= SUM_W'(row_n) + SUM_W'(col_n);
    end
  end
endmodule

// File: rtl/dual_tone_synth.sv
module dual_tone_synth
  import dtsynth_pkg::*;
#(
  parameter int unsigned DIV_W    = 8,
  parameter int unsigned ROW_GAIN = 101,
  parameter int unsigned COL_GAIN = 128,
  parameter int unsigned GAIN_SH  = 7,
  parameter int unsigned ROW_DIV [NUM_GRP] = '{160, 146, 132, 118},
  parameter int unsigned COL_DIV [NUM_GRP] = '{92, 84, 76, 68}
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        clk_en,
  input  logic        code_we,
  input  logic [3:0]  code,
  input  logic        tx_en,
  input  logic        single_tone,
  input  logic        col_sel,
  output logic [7:0]  row_smp,
  output logic [7:0]  col_smp,
  output logic [8:0]  tone_out
);
  grp_oh_t                 row_oh;
  grp_oh_t                 col_oh;
  phase_t                  row_phase;
  phase_t                  col_phase;
  logic signed [SMP_W-1:0] row_raw;
  logic signed [SMP_W-1:0] col_raw;
  logic signed [SMP_W-1:0] row_o;
  logic signed [SMP_W-1:0] col_o;
  logic signed [SUM_W-1:0] sum_o;
  logic                    restart;

  assign restart = code_we || !tx_en;

  dts_decoder u_dec (
    .clk    (clk),
    .rst    (rst),
    .code_we(code_we),
    .code   (code),
    .row_oh (row_oh),
    .col_oh (col_oh)
  );

  dts_tone_gen #(
    .DIV_W  (DIV_W),
    .GAIN   (ROW_GAIN),
    .GAIN_SH(GAIN_SH),
    .DIV_CNT(ROW_DIV)
  ) u_row (
    .clk    (clk),
    .rst    (rst),
    .clk_en (clk_en),
    .restart(restart),
    .sel_oh (row_oh),
    .phase  (row_phase),
    .smp    (row_raw)
  );

  dts_tone_gen #(
    .DIV_W  (DIV_W),
    .GAIN   (COL_GAIN),
    .GAIN_SH(GAIN_SH),
    .DIV_CNT(COL_DIV)
  ) u_col (
    .clk    (clk),
    .rst    (rst),
    .clk_en (clk_en),
    .restart(restart),
    .sel_oh (col_oh),
    .phase  (col_phase),
    .smp    (col_raw)
  );

  dts_mixer u_mix (
    .clk        (clk),
    .rst        (rst),
    .tx_en      (tx_en),
    .single_tone(single_tone),
    .col_sel    (col_sel),
    .row_raw    (row_raw),
    .col_raw    (col_raw),
    .row_smp    (row_o),
    .col_smp    (col_o),
    .tone_out   (sum_o)
  );

  assign row_smp  = row_o;
  assign col_smp  = col_o;
  assign tone_out = sum_o;
endmodule

// File: rtl/dts_checker.sv
module dts_checker (
  input logic       clk,
  input logic       rst,
  input logic       clk_en,
  input logic       code_we,
  input logic       tx_en,
  input logic       single_tone,
  input logic       col_sel,
  input logic [4:0] row_phase,
  input logic [4:0] col_phase,
  input logic [7:0] row_smp,
  input logic [7:0] col_smp,
  input logic [8:0] tone_out
);
  a_r4_sum_matches: assert property (@(posedge clk) disable iff (rst)
    $signed(tone_out) == $signed({row_smp[7], row_smp}) + $signed({col_smp[7], col_smp}));

  a_r6_gate_zero: assert property (@(posedge clk) disable iff (rst)
    !tx_en |=> (row_smp == 8'd0) && (col_smp == 8'd0) && (tone_out == 9'd0));

  a_r5_col_only: assert property (@(posedge clk) disable iff (rst)
    (single_tone && col_sel) |=> (row_smp == 8'd0));

  a_r5_row_only: assert property (@(posedge clk) disable iff (rst)
    (single_tone && !col_sel) |=> (col_smp == 8'd0));

  a_r7_restart_zero: assert property (@(posedge clk) disable iff (rst)
    code_we |=> (row_phase == 5'd0) && (col_phase == 5'd0));

  a_r8_hold_phase: assert property (@(posedge clk) disable iff (rst)
    (!clk_en && !code_we && tx_en) |=> $stable(row_phase) && $stable(col_phase));

  a_r2_no_min_code: assert property (@(posedge clk) disable iff (rst)
    (col_smp != 8'h80) && (row_smp != 8'h80));
endmodule

bind dual_tone_synth dts_checker u_chk (.*);

// File: tb/test_dual_tone_synth.sv
`timescale 1ns/1ps
module test_dual_tone_synth;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       clk_en = 1'b0;
  logic       code_we = 1'b0;
  logic [3:0] code = 4'd0;
  logic       tx_en = 1'b0;
  logic       single_tone = 1'b0;
  logic       col_sel = 1'b0;
  logic [7:0] row_smp;
  logic [7:0] col_smp;
  logic [8:0] tone_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dual_tone_synth i_dual_tone_synth (
    .clk(clk), .rst(rst), .clk_en(clk_en), .code_we(code_we), .code(code),
    .tx_en(tx_en), .single_tone(single_tone), .col_sel(col_sel),
    .row_smp(row_smp), .col_smp(col_smp), .tone_out(tone_out)
  );

  // reference model state
  int m_rc, m_cc, m_rdiv, m_cdiv, m_rph, m_cph;
  int m_rs, m_cs, m_orow, m_ocol, m_out;

  function automatic int row_count(input int k);
    case (k)
      1, 2, 3, 13:  return 160;
      4, 5, 6, 14:  return 146;
      7, 8, 9, 15:  return 132;
      default:      return 118;
    endcase
  endfunction

  function automatic int col_count(input int k);
    case (k)
      1, 4, 7, 11:  return 92;
      2, 5, 8, 10:  return 84;
      3, 6, 9, 12:  return 76;
      default:      return 68;
    endcase
  endfunction

  function automatic int col_val(input int p);
    real v;
    v = 127.0 * $sin(2.0 * 3.14159265358979 * p / 32.0);
    return (v >= 0.0) ? $rtoi(v + 0.5) : $rtoi(v - 0.5);
  endfunction

  function automatic int row_val(input int p);
    int c, m;
    c = col_val(p);
    m = ((c < 0 ? -c : c) * 101) / 128;
    return (c < 0) ? -m : m;
  endfunction

  task automatic fail_line(input string tag, input string what, input int act, input int exp);
    errors++;
    if (errors < 25) $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
  endtask

  // drive at negedge, model the edge, compare at the next negedge
  task automatic cyc(input bit r, input bit we, input int cd, input bit en, input bit tx,
                     input bit sg, input bit cs, input string tag);
    int n_orow, n_ocol, n_rs, n_cs;
    rst = r; code_we = we; code = 4'(cd); clk_en = en; tx_en = tx;
    single_tone = sg; col_sel = cs;
    @(posedge clk);
    if (r) begin
      m_rc = 118; m_cc = 68; m_rdiv = 0; m_cdiv = 0; m_rph = 0; m_cph = 0;
      m_rs = 0; m_cs = 0; m_orow = 0; m_ocol = 0; m_out = 0;
    end else begin
      n_orow = (tx && (!sg || !cs)) ? m_rs : 0;
      n_ocol = (tx && (!sg ||  cs)) ? m_cs : 0;
      n_rs = row_val(m_rph);
      n_cs = col_val(m_cph);
      if (we || !tx) begin
        m_rdiv = 0; m_cdiv = 0; m_rph = 0; m_cph = 0;
      end else if (en) begin
        if (m_rdiv == m_rc - 1) begin m_rdiv = 0; m_rph = (m_rph + 1) % 32; end
        else m_rdiv++;
        if (m_cdiv == m_cc - 1) begin m_cdiv = 0; m_cph = (m_cph + 1) % 32; end
        else m_cdiv++;
      end
      if (we) begin m_rc = row_count(cd); m_cc = col_count(cd); end
      m_orow = n_orow; m_ocol = n_ocol; m_out = n_orow + n_ocol;
      m_rs = n_rs; m_cs = n_cs;
    end
    @(negedge clk);
    checks++;
    if ($signed(row_smp) != m_orow) fail_line(tag, "row_smp", $signed(row_smp), m_orow);
    else if ($signed(col_smp) != m_ocol) fail_line(tag, "col_smp", $signed(col_smp), m_ocol);
    else if ($signed(tone_out) != m_out) fail_line(tag, "tone_out", $signed(tone_out), m_out);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    @(negedge clk);
    // R9: reset state
    for (int i = 0; i < 4; i++) cyc(1, 0, 0, 1, 1, 0, 0, "R9");
    // R9: default digit after reset, full row period at count 118
    for (int i = 0; i < 32 * 118 + 4; i++) cyc(0, 0, 0, 1, 1, 0, 0, "R9 R10");
    // R1 R2 R3 R4 R10: every key code, one full row period each
    for (int k = 0; k < 16; k++) begin
      cyc(0, 1, k, 1, 1, 0, 0, "R1 R7");
      for (int i = 0; i < 32 * row_count(k) + 3; i++)
        cyc(0, 0, 0, 1, 1, 0, 0, "R1 R2 R3 R4 R10");
    end
    // R5: single tone, column then row
    cyc(0, 1, 5, 1, 1, 1, 1, "R5");
    for (int i = 0; i < 3000; i++) cyc(0, 0, 0, 1, 1, 1, 1, "R5 col");
    for (int i = 0; i < 3000; i++) cyc(0, 0, 0, 1, 1, 1, 0, "R5 row");
    // R6: disable mid-tone, then re-enable from phase 0
    for (int i = 0; i < 40; i++) cyc(0, 0, 0, 1, 0, 0, 0, "R6");
    for (int i = 0; i < 2000; i++) cyc(0, 0, 0, 1, 1, 0, 0, "R6");
    // R8: ticks only on two of every three cycles
    cyc(0, 1, 9, 1, 1, 0, 0, "R8");
    for (int i = 0; i < 6000; i++) cyc(0, 0, 0, (i % 3) != 0, 1, 0, 0, "R8");
    // R7: rewrite mid-step and mid-period
    cyc(0, 1, 1, 1, 1, 0, 0, "R7");
    for (int i = 0; i < 777; i++) cyc(0, 0, 0, 1, 1, 0, 0, "R7");
    cyc(0, 1, 12, 1, 1, 0, 0, "R7");
    for (int i = 0; i < 2500; i++) cyc(0, 0, 0, 1, 1, 0, 0, "R7");
    // R8: no ticks at all, outputs frozen
    for (int i = 0; i < 300; i++) cyc(0, 0, 0, 0, 1, 0, 0, "R8 hold");
    finish_run();
  end
endmodule